// File: doc/BRIEF.md
# Splittable Signed Multiply-Accumulate Unit

This block is a multiply-accumulate datapath that can run as one wide unit or as two narrow ones. In wide mode it takes two 16-bit two's-complement operands, forms their 32-bit signed product from four 8x8 partial products, and adds that product into a 32-bit accumulator. In split mode the same hardware becomes two independent signed 8x8 multiply-accumulate lanes. The low bytes of the operands feed lane 0 and the high bytes feed lane 1. Each lane has its own 16-bit accumulator, and no carry passes between the lanes.

Three pipeline registers can each be kept or bypassed by a static parameter: the operand register, the product register and the output register. The accumulator register is always present. Each operand sample carries its own mode, load and clear controls through the pipeline, so the mode can change from one sample to the next. A valid strobe follows each sample to the output.

A 16-bit side output gives the upper half of the product word of the operation being presented. With `load` held high, the unit therefore also serves as a plain multiplier that returns the high half of the signed product.

Top module: `splitmac`

## Requirements
- R1: In wide mode (`split`=0) with `load`=1, `result` equals the signed product `a*b` as a 32-bit two's-complement value. This includes -32768 x -32768 = 0x40000000.
- R2: In wide mode with `load`=0 and `clr`=0, the product is added to the accumulator modulo 2^32. The carry out of bit 15 propagates into bit 16.
- R3: In split mode (`split`=1), `result[15:0]` accumulates `a[7:0]*b[7:0]` and `result[31:16]` accumulates `a[15:8]*b[15:8]`. Every byte is treated as signed and each lane wraps modulo 2^16. A lane overflow never changes the other lane, and -128 x -128 gives 0x4000 in a lane.
- R4: A valid sample with `load`=1 replaces the accumulator with its product, whatever the accumulator held before.
- R5: A sample with `clr`=1 sets the accumulator to zero, whether or not `in_valid` is high. Clear has priority over load and accumulate.
- R6: `out_valid` rises exactly IN_REG+PROD_REG+OUT_REG+1 enabled clock cycles after the sample with `in_valid`=1, and once for each such sample. A sample with `in_valid`=0 and `clr`=0 leaves the accumulator unchanged.
- R7: While `ce` is low, every register holds its value. `result` and `out_valid` do not change, and operands or controls applied during that time have no effect.
- R8: While `rst_n` is low, `result` is zero and `out_valid` is low.
- R9: `prod_hi` shows bits [31:16] of the product word of the operation that `out_valid` marks. This is the high half of the signed product in wide mode and the lane 1 product in split mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable for every register |
| split | input | 1 | 1 = two 8x8 lanes, 0 = one 16x16 unit; travels with the sample |
| in_valid | input | 1 | Operand sample is valid |
| a | input | 16 | Operand A, two's complement (per byte in split mode) |
| b | input | 16 | Operand B, two's complement (per byte in split mode) |
| load | input | 1 | Replace the accumulator with the product instead of adding |
| clr | input | 1 | Clear the accumulator |
| out_valid | output | 1 | Result corresponds to a valid sample |
| result | output | 32 | Accumulator contents (two 16-bit lanes in split mode) |
| prod_hi | output | 16 | Upper half of the product word of the marked operation |

## Verification
The hardest case to reach is a carry that must be blocked or passed at the lane boundary. This has to happen while the pipeline has different modes in flight from one sample to the next. The stimulus first loads a product of exactly 0xFFFF in the low half. It then adds a product of one, once in wide mode, where the carry must reach bit 16, and once in split mode, where the low lane must wrap to zero with the high lane untouched. Wide and split samples are interleaved back to back, and clock-enable gaps carrying junk operands and asserted controls are inserted. All eight bypass combinations run in parallel on the same stimulus, so each mode switch meets every possible pipeline depth.

// File: rtl/splitmac.sv
module splitmac #(
  parameter int LANE_W   = 8,
  parameter int IN_REG   = 1,
  parameter int PROD_REG = 1,
  parameter int OUT_REG  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                split,
  input  logic                in_valid,
  input  logic [2*LANE_W-1:0] a,
  input  logic [2*LANE_W-1:0] b,
  input  logic                load,
  input  logic                clr,
  output logic                out_valid,
  output logic [4*LANE_W-1:0] result,
  output logic [2*LANE_W-1:0] prod_hi
);
  localparam int OP_W   = 2 * LANE_W;
  localparam int ACC_W  = 2 * OP_W;
  localparam int HALF_W = OP_W;
  localparam int PP_W   = 2 * LANE_W + 2;

  logic [OP_W-1:0] s0_a, s0_b;
  logic            s0_split, s0_v, s0_ld, s0_clr;

  if (IN_REG != 0) begin : g_in_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s0_a <= '0; s0_b <= '0; s0_split <= 1'b0;
        s0_v <= 1'b0; s0_ld <= 1'b0; s0_clr <= 1'b0;
      end else if (ce) begin
        s0_a <= a; s0_b <= b; s0_split <= split;
        s0_v <= in_valid; s0_ld <= load; s0_clr <= clr;
      end
  end else begin : g_in_wire
    assign s0_a = a;
    assign s0_b = b;
    assign s0_split = split;
    assign s0_v = in_valid;
    assign s0_ld = load;
    assign s0_clr = clr;
  end

  // low bytes are unsigned digits in wide mode, signed lanes in split mode
  logic [LANE_W:0] al, bl, ah, bh;
  assign al = {s0_split & s0_a[LANE_W-1], s0_a[LANE_W-1:0]};
  assign bl = {s0_split & s0_b[LANE_W-1], s0_b[LANE_W-1:0]};
  assign ah = {s0_a[OP_W-1], s0_a[OP_W-1:LANE_W]};
  assign bh = {s0_b[OP_W-1], s0_b[OP_W-1:LANE_W]};

  logic signed [PP_W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
  assign pp_ll = $signed(al) * $signed(bl);
  assign pp_lh = $signed(al) * $signed(bh);
  assign pp_hl = $signed(ah) * $signed(bl);
  assign pp_hh = $signed(ah) * $signed(bh);

  logic signed [ACC_W-1:0] x_ll, x_lh, x_hl, x_hh, wide_p;
  assign x_ll = pp_ll;
  assign x_lh = pp_lh;
  assign x_hl = pp_hl;
  assign x_hh = pp_hh;
  assign wide_p = (x_hh <<< OP_W) + ((x_lh + x_hl) <<< LANE_W) + x_ll;

  logic [ACC_W-1:0] prod;
  assign prod = s0_split ? {pp_hh[HALF_W-1:0], pp_ll[HALF_W-1:0]} : wide_p;

  logic [ACC_W-1:0] s1_p;
  logic             s1_split, s1_v, s1_ld, s1_clr;

  if (PROD_REG != 0) begin : g_prod_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1_p <= '0; s1_split <= 1'b0;
        s1_v <= 1'b0; s1_ld <= 1'b0; s1_clr <= 1'b0;
      end else if (ce) begin
        s1_p <= prod; s1_split <= s0_split;
        s1_v <= s0_v; s1_ld <= s0_ld; s1_clr <= s0_clr;
      end
  end else begin : g_prod_wire
    assign s1_p = prod;
    assign s1_split = s0_split;
    assign s1_v = s0_v;
    assign s1_ld = s0_ld;
    assign s1_clr = s0_clr;
  end

  logic [ACC_W-1:0]  acc;
  logic [HALF_W-1:0] phold;
  logic              vacc;
  logic [HALF_W:0]   lo_sum;
  logic [HALF_W-1:0] hi_sum;

  assign lo_sum = {1'b0, acc[HALF_W-1:0]} + {1'b0, s1_p[HALF_W-1:0]};
  assign hi_sum = acc[ACC_W-1:HALF_W] + s1_p[ACC_W-1:HALF_W]
                + {{(HALF_W-1){1'b0}}, ~s1_split & lo_sum[HALF_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0; phold <= '0; vacc <= 1'b0;
    end else if (ce) begin
      vacc <= s1_v;
      if (s1_v) phold <= s1_p[ACC_W-1:HALF_W];
      if (s1_clr) acc <= '0;
      else if (s1_v) acc <= s1_ld ? s1_p : {hi_sum, lo_sum[HALF_W-1:0]};
    end

  if (OUT_REG != 0) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        result <= '0; prod_hi <= '0; out_valid <= 1'b0;
      end else if (ce) begin
        result <= acc; prod_hi <= phold; out_valid <= vacc;
      end
  end else begin : g_out_wire
    assign result = acc;
    assign prod_hi = phold;
    assign out_valid = vacc;
  end
endmodule

// File: rtl/splitmac_chk.sv
module splitmac_chk #(
  parameter int ACC_W  = 32,
  parameter int HALF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             s1_v,
  input logic             s1_ld,
  input logic             s1_clr,
  input logic             s1_split,
  input logic [ACC_W-1:0] s1_p,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] result,
  input logic             out_valid
);
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ce && s1_clr |=> acc == '0);

  a_r4_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    ce && s1_v && s1_ld && !s1_clr |=> acc == $past(s1_p));

  a_r2_wide_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ce && s1_v && !s1_ld && !s1_clr && !s1_split
    |=> acc == $past(acc) + $past(s1_p));

  a_r3_lanes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    ce && s1_v && !s1_ld && !s1_clr && s1_split
    |=> acc[ACC_W-1:HALF_W] == $past(acc[ACC_W-1:HALF_W]) + $past(s1_p[ACC_W-1:HALF_W])
     && acc[HALF_W-1:0] == $past(acc[HALF_W-1:0]) + $past(s1_p[HALF_W-1:0]));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !s1_v && !s1_clr |=> $stable(acc));

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(result) && $stable(out_valid) && $stable(acc));
endmodule

bind splitmac splitmac_chk #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .s1_v(s1_v), .s1_ld(s1_ld),
  .s1_clr(s1_clr), .s1_split(s1_split), .s1_p(s1_p), .acc(acc),
  .result(result), .out_valid(out_valid)
);

// File: tb/sim_splitmac.sv
`timescale 1ns/1ps
module sim_splitmac;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ce = 1'b1, split = 1'b0, in_valid = 1'b0, load = 1'b0, clr = 1'b0;
  logic [15:0] a = '0, b = '0;

  logic [31:0] res_w [8];
  logic [15:0] hi_w  [8];
  logic        ov_w  [8];
  logic [31:0] prev_res [8];

  for (genvar k = 0; k < 8; k++) begin : g_cfg
    splitmac #(.IN_REG(k % 2), .PROD_REG((k / 2) % 2), .OUT_REG(k / 4)) u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .split(split), .in_valid(in_valid),
      .a(a), .b(b), .load(load), .clr(clr),
      .out_valid(ov_w[k]), .result(res_w[k]), .prod_hi(hi_w[k]));
  end

  typedef struct {
    logic [31:0] res;
    logic [15:0] hi;
    int          cyc;
    string       req;
  } exp_t;
  exp_t q[$];

  int rd [8];
  int checks = 0, fails = 0, cyc = 0;
  logic ce_last = 1'b1;
  logic [31:0] acc_m = '0;
  bit started = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] prod_of(input logic [15:0] x, input logic [15:0] y, input bit sp);
    int p, l0, l1;
    if (!sp) begin
      p = int'($signed(x)) * int'($signed(y));
      return p;
    end
    l0 = int'($signed(x[7:0])) * int'($signed(y[7:0]));
    l1 = int'($signed(x[15:8])) * int'($signed(y[15:8]));
    return {l1[15:0], l0[15:0]};
  endfunction

  task automatic op(input logic [15:0] xa, input logic [15:0] xb, input bit sp,
                    input bit ld, input bit cl, input bit v, input string req);
    logic [31:0] p;
    logic [15:0] lo, hi;
    @(negedge clk);
    ce = 1'b1; a = xa; b = xb; split = sp; load = ld; clr = cl; in_valid = v;
    p = prod_of(xa, xb, sp);
    if (cl) acc_m = '0;
    else if (v) begin
      if (ld) acc_m = p;
      else if (!sp) acc_m = acc_m + p;
      else begin
        lo = acc_m[15:0] + p[15:0];
        hi = acc_m[31:16] + p[31:16];
        acc_m = {hi, lo};
      end
    end
    if (v) q.push_back('{acc_m, p[31:16], cyc, req});
  endtask

  task automatic idle(input int n);
    repeat (n) op(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0, "R6");
  endtask

  task automatic freeze(input int n);
    repeat (n) begin
      @(negedge clk);
      ce = 1'b0; in_valid = 1'b1; clr = 1'b1; load = 1'b1;
      a = 16'($urandom); b = 16'($urandom); split = 1'($urandom);
    end
  endtask

  always @(posedge clk) begin
    ce_last <= ce;
    if (rst_n && ce) cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      for (int k = 0; k < 8; k++) begin
        if (!ce_last)
          chk(res_w[k] === prev_res[k], "R7", "result moved while frozen", res_w[k], prev_res[k]);
        else if (ov_w[k]) begin
          if (rd[k] >= q.size())
            chk(1'b0, "R6", "unexpected out_valid", 32'(k), 32'(q.size()));
          else begin
            exp_t e;
            int lat;
            e = q[rd[k]];
            lat = (k % 2) + ((k / 2) % 2) + (k / 4) + 1;
            chk(res_w[k] === e.res, e.req, "result", res_w[k], e.res);
            chk(hi_w[k] === e.hi, "R9", "prod_hi", 32'(hi_w[k]), 32'(e.hi));
            chk(cyc - e.cyc == lat, "R6", "latency", 32'(cyc - e.cyc), 32'(lat));
            rd[k]++;
          end
        end
      end
    end
    for (int k = 0; k < 8; k++) prev_res[k] = res_w[k];
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) rd[k] = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk(res_w[k] === 32'h0, "R8", "result in reset", res_w[k], 32'h0);
      chk(ov_w[k] === 1'b0, "R8", "out_valid in reset", 32'(ov_w[k]), 32'h0);
    end
    rst_n = 1'b1;
    started = 1;
    idle(2);

    // R1 wide products
    op(16'h8000, 16'h8000, 0, 1, 0, 1, "R1");
    op(16'h7FFF, 16'h8000, 0, 1, 0, 1, "R1");
    op(16'hFFFF, 16'h0003, 0, 1, 0, 1, "R1");
    // R2 carry across the half boundary, then wrap
    op(16'd255, 16'd257, 0, 1, 0, 1, "R4");
    op(16'd1, 16'd1, 0, 0, 0, 1, "R2");
    op(16'h7FFF, 16'h7FFF, 0, 1, 0, 1, "R4");
    repeat (4) op(16'h7FFF, 16'h7FFF, 0, 0, 0, 1, "R2");
    op(16'h8000, 16'h8000, 0, 0, 0, 1, "R2");
    // R3 lanes: -128*-128 and a low lane wrap that must not carry
    op(16'h80FF, 16'h8001, 1, 1, 0, 1, "R3");
    op(16'h00FF, 16'h00FF, 1, 0, 0, 1, "R3");
    op(16'h7F80, 16'h7F80, 1, 0, 0, 1, "R3");
    // mode changes back to back
    op(16'd255, 16'd257, 1, 1, 0, 1, "R3");
    op(16'd1, 16'd1, 0, 0, 0, 1, "R2");
    op(16'h0101, 16'hFFFF, 1, 0, 0, 1, "R3");
    // R5 clear has priority, also without valid
    op(16'h1234, 16'h5678, 0, 1, 1, 1, "R5");
    op(16'h0300, 16'h0200, 1, 0, 0, 1, "R5");
    op(16'h0000, 16'h0000, 0, 0, 1, 0, "R5");
    op(16'h0002, 16'h0003, 0, 0, 0, 1, "R5");
    // R6 invalid samples ignored
    idle(3);
    op(16'h0004, 16'h0005, 0, 0, 0, 1, "R6");
    // R7 freeze with junk
    freeze(4);
    op(16'hFFFE, 16'h0007, 0, 0, 0, 1, "R7");
    freeze(2);
    op(16'h0203, 16'h0405, 1, 1, 0, 1, "R7");
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) freeze($urandom_range(1, 3));
      else op(16'($urandom), 16'($urandom), 1'($urandom), r < 4, r == 4, r != 5,
              (r % 2) ? "R2" : "R3");
    end
    idle(10);
    for (int k = 0; k < 8; k++)
      chk(rd[k] == q.size(), "R6", "all results delivered", 32'(rd[k]), 32'(q.size()));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule